// File: doc/BRIEF.md
# Credit-Paced Configuration Stream Engine

This block takes a configuration image from a host, one 32-bit word per register write, and hands it to a downstream sink over a valid/ready port. The host reads a credit count and writes only while credit remains. It does not watch a ready signal. The credit count is the number of free slots in the internal word queue. Decoding the image and programming the fabric are left to the sink.

A transfer follows this sequence:

1. The host raises the engine-reset request and waits for the acknowledge.
2. It drops the request and selects a target region.
3. It sets the start bit and pushes words while credit remains.
4. It sets the complete bit.
5. Hardware clears start and complete once the queue has drained.

Misuse of the data register is recorded in a sticky error register, which the host clears by writing ones. The same register records fault strobes from the sink.

Top module: `cfg_stream_engine`

## Requirements
- R1: After `rst_n` is released, the following hold:
  - control (0x08) reads 0;
  - status (0x10) reads the full credit `DEPTH` in bits 8:0 and zero elsewhere;
  - error (0x20) reads 0;
  - `snk_valid` is low.
- R2: Writing control bit 0 = 1 requests an engine reset, which has these effects:
  - it empties the queue and restores full credit;
  - it clears start and complete, and holds them clear while bit 0 stays set;
  - the acknowledge, control bit 4, reads 1 from the second clock edge after the write;
  - writing bit 0 = 0 drops the acknowledge one edge later;
  - the error bits are left unchanged.
- R3: Control bits 9:7 hold a 3-bit region number. The value written reads back in those bits and drives `snk_region`.
- R4: Writing 1 to control bit 12 sets start. Writing 0 to it has no effect. Writing 1 to bit 13 sets complete only while start is already set.
- R5: A write to data (0x18) while start is set and complete is clear queues `wdata[31:0]` and lowers the credit by one. Bits 63:32 are ignored. The sink receives the words in write order, and `snk_data` holds while `snk_valid` is high and `snk_ready` is low.
- R6: Each word taken by the sink (`snk_valid` and `snk_ready` high at an edge) returns one credit. Credit never exceeds `DEPTH`.
- R7: When start and complete are both set and the queue is empty, hardware clears both at the next edge.
- R8: A data write while start is clear, or while complete is set, sets error bit 3 (protocol). The word is discarded and the credit is unchanged.
- R9: A data write while the credit is 0 sets error bit 4 (overflow). The word is discarded.
- R10: Each sink strobe sets its own error bit:
  - `snk_op_err` sets bit 0;
  - `snk_crc_err` sets bit 1;
  - `snk_image_err` sets bit 2.
- R11: Writing error (0x20) clears exactly the bits written as 1. A strobe in the same cycle as a clear of its bit wins, and the bit stays set.
- R12: The status register carries three state fields:
  - Bit 16 is 0 only when all of these hold: no reset request, start clear, queue empty, and no error bit set.
  - Bits 22:20 carry the controller state: 0 idle, 1 in reset, 2 accepting, 3 draining.
  - Bits 27:24 carry the host state: 8 if any error bit is set, otherwise 1 while accepting, 2 while draining, 0 idle.
- R13: The following reads return fixed values:
  - 0x00 returns `HDR_VAL`;
  - 0xA8 returns `ID_LO_VAL`;
  - 0xB0 returns `ID_HI_VAL`;
  - any other offset returns 0.

  Writes to these offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr`, combinational |
| snk_valid | output | 1 | Queue head is valid |
| snk_data | output | 32 | Queue head word |
| snk_region | output | 3 | Selected region number |
| snk_ready | input | 1 | Sink takes the head word |
| snk_op_err | input | 1 | Sink operation fault strobe |
| snk_crc_err | input | 1 | Sink CRC fault strobe |
| snk_image_err | input | 1 | Sink incompatible image strobe |

## Verification
A queue pointer or count that has gone wrong shows up at the ports in two ways. The credit field no longer equals `DEPTH` minus the words outstanding at the next status read. The word stream on the sink also drifts out of order, or contains a word the host never pushed, on the very next handshake. A start or complete bit left in the wrong state shows the same cycle through the following symptoms:
- a protocol error raised on a write that should have been accepted;
- a completion that never clears;
- wrong state codes in the status register.

A lost error bit is visible at the next error-register read.

// File: rtl/cfg_stream_engine.sv
module cfg_stream_engine #(
  parameter int          DEPTH     = 16,
  parameter logic [63:0] HDR_VAL   = 64'h3000_0000_1000_0005,
  parameter logic [63:0] ID_LO_VAL = 64'h0123_4567_89AB_CDEF,
  parameter logic [63:0] ID_HI_VAL = 64'hFEDC_BA98_7654_3210
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [63:0] bus_wdata,
  output logic [63:0] bus_rdata,
  output logic        snk_valid,
  output logic [31:0] snk_data,
  output logic [2:0]  snk_region,
  input  logic        snk_ready,
  input  logic        snk_op_err,
  input  logic        snk_crc_err,
  input  logic        snk_image_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [7:0] A_HDR  = 8'h00;
  localparam logic [7:0] A_CTRL = 8'h08;
  localparam logic [7:0] A_STAT = 8'h10;
  localparam logic [7:0] A_DATA = 8'h18;
  localparam logic [7:0] A_ERR  = 8'h20;
  localparam logic [7:0] A_IDL  = 8'hA8;
  localparam logic [7:0] A_IDH  = 8'hB0;

  logic          rst_req, rst_ack, start, done_req;
  logic [2:0]    region;
  logic [4:0]    err;
  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;

  logic wr_ctrl, wr_data, wr_err, eng_rst, accepting, full, empty, push, pop, finish;
  logic proto_ev, ovf_ev;
  logic [4:0] err_set, err_clr;
  logic [8:0] credit;
  logic [2:0] ctl_code;
  logic [3:0] host_code;
  logic       busy;

  assign wr_ctrl   = bus_wr && bus_addr == A_CTRL;
  assign wr_data   = bus_wr && bus_addr == A_DATA;
  assign wr_err    = bus_wr && bus_addr == A_ERR;
  assign eng_rst   = rst_req || (wr_ctrl && bus_wdata[0]);
  assign accepting = start && !done_req;
  assign full      = count == CW'(DEPTH);
  assign empty     = count == '0;
  assign push      = wr_data && accepting && !full && !eng_rst;
  assign pop       = snk_valid && snk_ready;
  assign finish    = start && done_req && empty;
  assign proto_ev  = wr_data && !accepting;
  assign ovf_ev    = wr_data && accepting && full;
  assign err_set   = {ovf_ev, proto_ev, snk_image_err, snk_crc_err, snk_op_err};
  assign err_clr   = wr_err ? bus_wdata[4:0] : 5'b0;

  assign credit    = 9'(DEPTH) - 9'(count);
  assign ctl_code  = rst_req ? 3'd1 : accepting ? 3'd2 : start ? 3'd3 : 3'd0;
  assign host_code = (|err) ? 4'd8 : accepting ? 4'd1 : start ? 4'd2 : 4'd0;
  assign busy      = rst_req || start || !empty || (|err);

  assign snk_valid  = !empty;
  assign snk_data   = mem[rp];
  assign snk_region = region;

  always_comb begin
    case (bus_addr)
      A_HDR:   bus_rdata = HDR_VAL;
      A_CTRL:  bus_rdata = {50'b0, done_req, start, 2'b0, region, 2'b0, rst_ack, 3'b0, rst_req};
      A_STAT:  bus_rdata = {36'b0, host_code, 1'b0, ctl_code, 3'b0, busy, 7'b0, credit};
      A_ERR:   bus_rdata = {59'b0, err};
      A_IDL:   bus_rdata = ID_LO_VAL;
      A_IDH:   bus_rdata = ID_HI_VAL;
      default: bus_rdata = 64'b0;
    endcase
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= bus_wdata[31:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else if (eng_rst) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      rst_ack  <= 1'b0;
      region   <= 3'b0;
      start    <= 1'b0;
      done_req <= 1'b0;
      err      <= 5'b0;
    end else begin
      rst_ack <= rst_req;
      if (wr_ctrl) begin
        rst_req <= bus_wdata[0];
        region  <= bus_wdata[9:7];
      end
      if (eng_rst || finish)              start <= 1'b0;
      else if (wr_ctrl && bus_wdata[12])  start <= 1'b1;
      if (eng_rst || finish)                      done_req <= 1'b0;
      else if (wr_ctrl && bus_wdata[13] && start) done_req <= 1'b1;
      err <= (err & ~err_clr) | err_set;
    end
  end
endmodule

module cfg_stream_engine_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [7:0]    bus_addr,
  input logic [63:0]   bus_wdata,
  input logic          snk_valid,
  input logic          snk_ready,
  input logic [31:0]   snk_data,
  input logic          rst_req,
  input logic          start,
  input logic          done_req,
  input logic [CW-1:0] count,
  input logic [4:0]    err
);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 8'h18 && start && !done_req && count == CW'(DEPTH) |=> err[4]);
  // R8
  proto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 8'h18 && !start |=> err[3] && $stable(count));
  // R2
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> count == '0 && !start && !done_req);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snk_valid && !snk_ready && !rst_req && !(bus_wr && bus_addr == 8'h08 && bus_wdata[0])
    |=> snk_valid && $stable(snk_data));
  // R11
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 8'h20) |=> (err & $past(err)) == $past(err));
  // R6
  credit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R7
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && done_req && count == '0 |=> !start && !done_req);
endmodule

bind cfg_stream_engine cfg_stream_engine_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data), .rst_req(rst_req),
  .start(start), .done_req(done_req), .count(count), .err(err)
);

// File: tb/cfg_stream_engine_test.sv
module cfg_stream_engine_test;
  localparam int          DEPTH = 16;
  localparam logic [63:0] HDR   = 64'h3000_0000_1000_0005;
  localparam logic [63:0] IDL   = 64'h1111_2222_3333_4444;
  localparam logic [63:0] IDH   = 64'h5555_6666_7777_8888;
  localparam logic [7:0]  A_HDR = 8'h00, A_CTRL = 8'h08, A_STAT = 8'h10, A_DATA = 8'h18,
                          A_ERR = 8'h20, A_IDL = 8'hA8, A_IDH = 8'hB0;

  logic clk = 0, rst_n = 0, bus_wr = 0, snk_ready = 0;
  logic snk_op_err = 0, snk_crc_err = 0, snk_image_err = 0;
  logic [7:0] bus_addr = 0;
  logic [63:0] bus_wdata = 0, bus_rdata, v;
  logic snk_valid;
  logic [31:0] snk_data;
  logic [2:0] snk_region;
  int checks = 0, fails = 0;
  bit sink_on = 0;
  logic [31:0] exp_q[$];

  always #5 clk = ~clk;

  cfg_stream_engine #(.DEPTH(DEPTH), .HDR_VAL(HDR), .ID_LO_VAL(IDL), .ID_HI_VAL(IDH)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .snk_valid(snk_valid), .snk_data(snk_data), .snk_region(snk_region),
    .snk_ready(snk_ready), .snk_op_err(snk_op_err), .snk_crc_err(snk_crc_err),
    .snk_image_err(snk_image_err));

  function automatic logic [63:0] stat_val(int credit, bit busy, int ctl, int host);
    return 64'(credit) | (64'(busy) << 16) | (64'(ctl) << 20) | (64'(host) << 24);
  endfunction

  function automatic logic [63:0] ctrl_val(bit rq, bit ack, int reg_n, bit st, bit cp);
    return 64'(rq) | (64'(ack) << 4) | (64'(reg_n) << 7) | (64'(st) << 12) | (64'(cp) << 13);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic push(input logic [31:0] w);
    wr(A_DATA, {$urandom(), w});
    exp_q.push_back(w);
  endtask

  task automatic drain();
    int g = 0;
    while (exp_q.size() != 0 && g < 2000) begin tick(1); g++; end
    tick(2);
  endtask

  task automatic sink_off();
    sink_on = 0;
    tick(2);
  endtask

  // sink driver and monitor
  always @(negedge clk) begin
    snk_ready = sink_on && ($urandom() % 4 != 0);
    #1;
    if (snk_valid && snk_ready) begin
      if (exp_q.size() == 0) chk("R5 unexpected word", 64'(snk_data), 64'hX);
      else chk("R5 order", 64'(snk_data), 64'(exp_q.pop_front()));
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    rst_n = 1;
    tick(1);
    // R1
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_STAT, v); chk("R1 status", v, stat_val(DEPTH, 0, 0, 0));
    rd(A_ERR, v);  chk("R1 err", v, 0);
    chk("R1 valid", 64'(snk_valid), 0);
    // R13
    rd(A_HDR, v); chk("R13 hdr", v, HDR);
    wr(A_IDL, 64'h0);
    rd(A_IDL, v); chk("R13 id lo", v, IDL);
    rd(A_IDH, v); chk("R13 id hi", v, IDH);
    rd(8'h40, v); chk("R13 unmapped", v, 0);
    // R8 write while idle
    wr(A_DATA, 64'h1234);
    rd(A_ERR, v); chk("R8 proto idle", v, 64'h8);
    rd(A_STAT, v); chk("R8 credit kept", v[8:0], DEPTH);
    rd(A_STAT, v); chk("R12 error busy", v, stat_val(DEPTH, 1, 0, 8));
    // R11
    wr(A_ERR, 64'h8);
    rd(A_ERR, v); chk("R11 clear", v, 0);
    rd(A_STAT, v); chk("R12 idle", v, stat_val(DEPTH, 0, 0, 0));
    // R2 / R3
    wr(A_CTRL, ctrl_val(1, 0, 5, 1, 0));
    tick(1);
    rd(A_CTRL, v); chk("R2 ack set", v, ctrl_val(1, 1, 5, 0, 0));
    chk("R3 region pin", 64'(snk_region), 5);
    rd(A_STAT, v); chk("R12 reset code", v, stat_val(DEPTH, 1, 1, 0));
    wr(A_CTRL, ctrl_val(0, 0, 5, 0, 0));
    tick(1);
    rd(A_CTRL, v); chk("R2 ack drop", v, ctrl_val(0, 0, 5, 0, 0));
    // R4
    wr(A_CTRL, ctrl_val(0, 0, 5, 0, 1));
    rd(A_CTRL, v); chk("R4 complete needs start", v[13], 0);
    wr(A_CTRL, ctrl_val(0, 0, 5, 1, 0));
    rd(A_CTRL, v); chk("R4 start set", v, ctrl_val(0, 0, 5, 1, 0));
    rd(A_STAT, v); chk("R12 accepting", v, stat_val(DEPTH, 1, 2, 1));
    wr(A_CTRL, ctrl_val(0, 0, 5, 0, 0));
    rd(A_CTRL, v); chk("R4 write 0 keeps start", v[12], 1);
    // R5 / R9 fill with sink stalled
    for (int i = 0; i < DEPTH; i++) begin
      push($urandom());
      rd(A_STAT, v); chk("R5 credit drop", v[8:0], DEPTH - 1 - i);
    end
    wr(A_DATA, 64'hABCD);
    rd(A_ERR, v);  chk("R9 overflow", v, 64'h10);
    rd(A_STAT, v); chk("R9 credit zero", v[8:0], 0);
    rd(A_STAT, v); chk("R12 error host code", v[27:24], 8);
    wr(A_ERR, 64'h10);
    // R6 drain
    sink_on = 1;
    drain();
    sink_off();
    rd(A_STAT, v); chk("R6 credit back", v[8:0], DEPTH);
    // random phase
    sink_on = 1;
    for (int r = 0; r < 300; r++) begin
      rd(A_STAT, v);
      if (v[8:0] != 0 && $urandom() % 3 != 0) push($urandom());
      else tick(1);
    end
    drain();
    sink_off();
    rd(A_STAT, v); chk("R6 credit after random", v[8:0], DEPTH);
    // R8 after complete, R7 completion
    push(32'hA5A5_0001);
    push(32'hA5A5_0002);
    wr(A_CTRL, ctrl_val(0, 0, 5, 1, 1));
    rd(A_STAT, v); chk("R12 draining", v, stat_val(DEPTH - 2, 1, 3, 2));
    wr(A_DATA, 64'h77);
    rd(A_ERR, v);  chk("R8 proto after complete", v, 64'h8);
    rd(A_STAT, v); chk("R8 discarded", v[8:0], DEPTH - 2);
    rd(A_CTRL, v); chk("R7 held while data", v[13:12], 2'b11);
    wr(A_ERR, 64'h1F);
    sink_on = 1;
    drain();
    rd(A_CTRL, v); chk("R7 cleared", v, ctrl_val(0, 0, 5, 0, 0));
    sink_off();
    // R10
    snk_op_err = 1; tick(1); snk_op_err = 0;
    rd(A_ERR, v); chk("R10 op", v, 64'h1);
    snk_crc_err = 1; tick(1); snk_crc_err = 0;
    rd(A_ERR, v); chk("R10 crc", v, 64'h3);
    snk_image_err = 1; tick(1); snk_image_err = 0;
    rd(A_ERR, v); chk("R10 image", v, 64'h7);
    // R11 partial clear and set wins
    wr(A_ERR, 64'h1);
    rd(A_ERR, v); chk("R11 partial", v, 64'h6);
    snk_crc_err = 1;
    wr(A_ERR, 64'h2);
    snk_crc_err = 0;
    rd(A_ERR, v); chk("R11 set wins", v, 64'h6);
    // R2 flush keeps errors
    wr(A_CTRL, ctrl_val(0, 0, 2, 1, 0));
    push(32'h1); push(32'h2); push(32'h3);
    wr(A_CTRL, ctrl_val(1, 0, 2, 1, 0));
    exp_q.delete();
    tick(1);
    rd(A_STAT, v); chk("R2 credit restored", v[8:0], DEPTH);
    chk("R2 valid low", 64'(snk_valid), 0);
    rd(A_CTRL, v); chk("R2 start cleared", v, ctrl_val(1, 1, 2, 0, 0));
    rd(A_ERR, v);  chk("R2 errors kept", v, 64'h6);
    wr(A_CTRL, 64'h0);
    wr(A_ERR, 64'h1F);
    tick(1);
    rd(A_STAT, v); chk("R12 idle end", v, stat_val(DEPTH, 0, 0, 0));
    chk("R5 queue empty", 64'(exp_q.size()), 0);
    finish_run();
  end
endmodule